// File: doc/BRIEF.md
# Serial-Loaded DAC Control Interface

This block is the digital front end of a 16-bit voltage-output converter. A host sends 24-bit words over three pins: an active-low frame select, a serial clock and a data line. The block samples all three with its own faster system clock. Only a word that completes its 24th serial clock fall while the frame select is still low changes anything. The last sixteen bits of the word become the converter code, and the two bits above them choose one of four output conditions. One condition is normal drive. The other three are power-down states: output floating, output pulled to ground through a high-value resistor, or output pulled to ground through a low-value resistor. The block turns that choice into one-hot switch enables for the analog output stage.

At reset the code register holds zero-scale or midscale, as selected by a strap parameter, and the output stage is in normal drive. A word of all ones is a software reset. It restores that reset code and normal drive. Each committed word raises a one-cycle update strobe.

The serial pins carry no back-pressure. The block accepts a bit on every serial clock fall, provided the system clock runs at least four times faster than the serial clock.

Top module: `dac_serial_front`

## Requirements
- R1: After reset, `dac_code` equals the strap reset code (0x8000 when `RESET_MIDSCALE`=1, the default; 0x0000 otherwise). `pd_mode` is 00, `amp_en` is 1, the three termination enables are 0, and `update_stb` is 0.
- R2: Bits are taken most significant first, one on each serial clock fall while the frame select is low. On the 24th fall, word bits [15:0] go to `dac_code` and bits [17:16] go to `pd_mode`, both in one cycle, and `update_stb` is high for exactly one cycle. Bits [23:18] have no effect unless all 24 bits are ones.
- R3: The output-stage enables decode from `pd_mode`. Mode 00 sets `amp_en`, 01 sets `out_hiz`, 10 sets `shunt_100k_en` and 11 sets `shunt_1k_en`. Exactly one of the four enables is high at any time.
- R4: In every power-down mode, `amp_en` is 0 and `dac_code` holds the value written by the last committed word.
- R5: If the frame select rises before the 24th serial clock fall, the partial word is dropped. `dac_code` and `pd_mode` keep their values and no update strobe occurs.
- R6: After the 24th fall, further serial clock falls while the frame select stays low have no effect. A new word begins only after the frame select goes high and then falls again.
- R7: A word of all ones (0xFFFFFF) loads the strap reset code into `dac_code`, sets `pd_mode` to 00 and pulses `update_stb`. This holds even if the frame select rises right after the 24th fall.
- R8: `dac_code` and `pd_mode` change only in cycles where `update_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial clock from the host; data is taken on its falling edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| dac_code | output | 16 | Code driven to the converter core |
| pd_mode | output | 2 | Current output mode (00 normal, 01 float, 10 high-value pull-down, 11 low-value pull-down) |
| amp_en | output | 1 | Output amplifier enable |
| out_hiz | output | 1 | Output left floating |
| shunt_100k_en | output | 1 | High-value resistor to ground enable |
| shunt_1k_en | output | 1 | Low-value resistor to ground enable |
| update_stb | output | 1 | One-cycle pulse on every committed word |

## Verification
The assertions assume that the system clock sees every serial clock phase for at least two cycles. They also assume that the frame select never moves in the same sample as a serial clock fall, and that committed words are at least 24 serial clocks apart, so two strobes never fall in adjacent cycles. The stimulus uses a serial clock period of eight system cycles. It sets the data line four cycles before each fall and holds it until the following rise. It moves the frame select only while the serial clock is high and, after each move, waits four cycles before the next edge.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_FLOAT  = 2'b01,
    PD_R100K  = 2'b10,
    PD_R1K    = 2'b11
  } pd_mode_e;

  typedef struct packed {
    logic amp;
    logic hiz;
    logic r100k;
    logic r1k;
  } out_ctrl_t;

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/dac_fe_framer.sv
module dac_fe_framer #(
  parameter int FRAME_W = 24,
  localparam int CW = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n_s,
  input  logic               sck_s,
  input  logic               sdi_s,
  output logic               armed,
  output logic               word_pulse,
  output logic [FRAME_W-1:0] word
);

  logic          sel_prev, sck_prev;
  logic [CW-1:0] bit_cnt;
  logic          sel_fall, sck_fall;

  assign sel_fall = sel_prev & ~sel_n_s;
  assign sck_fall = sck_prev & ~sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      sel_prev <= sel_n_s;
      sck_prev <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      bit_cnt    <= '0;
      word       <= '0;
      word_pulse <= 1'b0;
    end else begin
      word_pulse <= 1'b0;
      if (sel_n_s) begin
        // select high: any unfinished word is dropped
        armed   <= 1'b0;
        bit_cnt <= '0;
        word    <= '0;
      end else if (sel_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
        word    <= '0;
      end else if (armed && sck_fall) begin
        word <= {word[FRAME_W-2:0], sdi_s};
        if (bit_cnt == CW'(FRAME_W - 1)) begin
          armed      <= 1'b0;
          word_pulse <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode
  import dac_fe_pkg::*;
(
  input  logic [1:0] mode,
  output out_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (pd_mode_e'(mode))
      PD_NORMAL: ctrl.amp   = 1'b1;
      PD_FLOAT:  ctrl.hiz   = 1'b1;
      PD_R100K:  ctrl.r100k = 1'b1;
      PD_R1K:    ctrl.r1k   = 1'b1;
      default:   ctrl.amp   = 1'b1;
    endcase
  end

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_fe_pkg::*;
#(
  parameter int CODE_W         = 16,
  parameter int FRAME_W        = 24,
  parameter bit RESET_MIDSCALE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic              amp_en,
  output logic              out_hiz,
  output logic              shunt_100k_en,
  output logic              shunt_1k_en,
  output logic              update_stb
);

  localparam logic [CODE_W-1:0] RESET_CODE =
    RESET_MIDSCALE ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  localparam int MODE_LO = CODE_W;

  logic [2:0]         pins_s;
  logic               sync_s, sck_s, sdi_s;
  logic               frm_armed, frm_pulse;
  logic [FRAME_W-1:0] frm_word;
  out_ctrl_t          ctrl;

  dac_fe_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({frame_n, ser_clk, ser_data}),
    .q_sync  (pins_s)
  );

  assign sync_s = pins_s[2];
  assign sck_s  = pins_s[1];
  assign sdi_s  = pins_s[0];

  dac_fe_framer #(.FRAME_W(FRAME_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n_s    (sync_s),
    .sck_s      (sck_s),
    .sdi_s      (sdi_s),
    .armed      (frm_armed),
    .word_pulse (frm_pulse),
    .word       (frm_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code   <= RESET_CODE;
      pd_mode    <= PD_NORMAL;
      update_stb <= 1'b0;
    end else begin
      update_stb <= frm_pulse;
      if (frm_pulse) begin
        if (&frm_word) begin
          dac_code <= RESET_CODE;
          pd_mode  <= PD_NORMAL;
        end else begin
          dac_code <= frm_word[CODE_W-1:0];
          pd_mode  <= frm_word[MODE_LO+1:MODE_LO];
        end
      end
    end
  end

  dac_fe_decode u_decode (
    .mode (pd_mode),
    .ctrl (ctrl)
  );

  assign amp_en        = ctrl.amp;
  assign out_hiz       = ctrl.hiz;
  assign shunt_100k_en = ctrl.r100k;
  assign shunt_1k_en   = ctrl.r1k;

endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic [1:0]        pd_mode,
  input logic              amp_en,
  input logic              out_hiz,
  input logic              shunt_100k_en,
  input logic              shunt_1k_en,
  input logic              update_stb,
  input logic              frm_armed,
  input logic              sync_s,
  input logic              frm_pulse
);

  assert_one_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({amp_en, out_hiz, shunt_100k_en, shunt_1k_en}) == 1);

  assert_pd_no_amp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hiz || shunt_100k_en || shunt_1k_en) |-> !amp_en);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |=> !update_stb);

  assert_abort_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_armed && sync_s) |=> !frm_pulse);

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> update_stb);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_mode) |-> update_stb);

endmodule

bind dac_serial_front dac_serial_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dac_code      (dac_code),
  .pd_mode       (pd_mode),
  .amp_en        (amp_en),
  .out_hiz       (out_hiz),
  .shunt_100k_en (shunt_100k_en),
  .shunt_1k_en   (shunt_1k_en),
  .update_stb    (update_stb),
  .frm_armed     (frm_armed),
  .sync_s        (sync_s),
  .frm_pulse     (frm_pulse)
);

// File: tb/sim_dac_serial_front.sv
`timescale 1ns/1ps
module sim_dac_serial_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_data = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic        amp_en, out_hiz, shunt_100k_en, shunt_1k_en, update_stb;

  int n_run = 0;
  int n_fail = 0;
  int stb_cnt = 0;

  always #10 clk = ~clk;

  dac_serial_front u0 (
    .clk (clk), .rst_n (rst_n), .frame_n (frame_n), .ser_clk (ser_clk),
    .ser_data (ser_data), .dac_code (dac_code), .pd_mode (pd_mode),
    .amp_en (amp_en), .out_hiz (out_hiz), .shunt_100k_en (shunt_100k_en),
    .shunt_1k_en (shunt_1k_en), .update_stb (update_stb)
  );

  always @(posedge clk) if (rst_n && update_stb) stb_cnt <= stb_cnt + 1;

  // {word[23:0], expected code[15:0], expected mode[1:0]}
  localparam logic [41:0] VEC [8] = '{
    {24'h001234, 16'h1234, 2'b00},
    {24'h01ABCD, 16'hABCD, 2'b01},
    {24'h02FFFF, 16'hFFFF, 2'b10},
    {24'h030000, 16'h0000, 2'b11},
    {24'h005555, 16'h5555, 2'b00},
    {24'h03AAAA, 16'hAAAA, 2'b11},
    {24'hFC1234, 16'h1234, 2'b00},
    {24'h010001, 16'h0001, 2'b01}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clock_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = w[23-i];
      tick(4);
      ser_clk = 1'b0;
      tick(4);
      ser_clk = 1'b1;
    end
  endtask

  task automatic send(input logic [23:0] w, input int n, input bit keep_low);
    frame_n = 1'b0;
    tick(4);
    clock_bits(w, n);
    tick(4);
    if (!keep_low) frame_n = 1'b1;
    tick(8);
  endtask

  function automatic logic [3:0] ctrl_of(input logic [1:0] m);
    case (m)
      2'b00:   return 4'b1000;
      2'b01:   return 4'b0100;
      2'b10:   return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int s0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 code", dac_code, 16'h8000);
    chk("R1 mode", pd_mode, 2'b00);
    chk("R1 ctrl", {amp_en, out_hiz, shunt_100k_en, shunt_1k_en}, 4'b1000);
    chk("R1 strobe", stb_cnt, 0);

    // R2 R3 R4 vector walk
    for (int v = 0; v < 8; v++) begin
      s0 = stb_cnt;
      send(VEC[v][41:18], 24, 1'b0);
      chk("R2 code", dac_code, VEC[v][17:2]);
      chk("R2 mode", pd_mode, VEC[v][1:0]);
      chk("R3 ctrl", {amp_en, out_hiz, shunt_100k_en, shunt_1k_en}, ctrl_of(VEC[v][1:0]));
      chk("R2 strobe", stb_cnt, s0 + 1);
    end

    // R5 abort after 10 bits and after 23 bits
    send(24'h001111, 24, 1'b0);
    s0 = stb_cnt;
    send(24'h03EEEE, 10, 1'b0);
    chk("R5 code10", dac_code, 16'h1111);
    chk("R5 mode10", pd_mode, 2'b00);
    send(24'h02DDDD, 23, 1'b0);
    chk("R5 code23", dac_code, 16'h1111);
    chk("R5 mode23", pd_mode, 2'b00);
    chk("R5 strobe", stb_cnt, s0);

    // R6 extra falls while select stays low
    s0 = stb_cnt;
    send(24'h002222, 24, 1'b1);
    clock_bits(24'h013333, 24);
    tick(8);
    chk("R6 code", dac_code, 16'h2222);
    chk("R6 mode", pd_mode, 2'b00);
    frame_n = 1'b1;
    tick(8);
    chk("R6 strobe", stb_cnt, s0 + 1);
    send(24'h014444, 24, 1'b0);
    chk("R6 rearm", dac_code, 16'h4444);

    // R4 power-down keeps code
    send(24'h034444, 24, 1'b0);
    chk("R4 code", dac_code, 16'h4444);
    chk("R4 amp", amp_en, 1'b0);

    // R7 software reset
    s0 = stb_cnt;
    send(24'hFFFFFF, 24, 1'b0);
    chk("R7 code", dac_code, 16'h8000);
    chk("R7 mode", pd_mode, 2'b00);
    chk("R7 ctrl", {amp_en, out_hiz, shunt_100k_en, shunt_1k_en}, 4'b1000);
    chk("R7 strobe", stb_cnt, s0 + 1);

    // R8 no change while idle
    tick(40);
    chk("R8 idle", dac_code, 16'h8000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule